// File: doc/BRIEF.md
# Partial-Access Register File

This block stores eight 32-bit general-purpose registers. It has two independent read ports and one write port. Each port takes a register index and a two-bit access-size selector. Software-visible narrow views of a register are carried out in hardware. A narrow read returns the selected field zero-extended and aligned to bit 0. A narrow write replaces only the selected field and keeps every other bit of the register.

The lower half of the file, indices 0 to 3, allows all four access sizes: full word, low half, low byte and second byte. The upper half, indices 4 to 7, allows only the full word and the low half. A byte-size access to an upper register is flagged as illegal. An illegal write is dropped, and an illegal read returns zero.

Read results and flags are registered, so they appear one cycle after the request. A write and a read of the same register in the same cycle return the value after the write.

Top module: `prf_regfile`

## Requirements
- R1: A synchronous active-high reset clears all registers, both read data outputs and all three illegal flags to zero.
- R2: Size code 2'b00 selects the full 32 bits. A full write replaces the register, and a full read returns it on the cycle after the request.
- R3: Size code 2'b01 selects bits 15:0. A read returns them zero-extended to 32 bits.
- R4: Size code 2'b10 selects bits 7:0. A read returns them zero-extended to 32 bits.
- R5: Size code 2'b11 selects bits 15:8. A read returns them shifted down to bits 7:0, with bits 31:8 zero.
- R6: A narrow write changes only the selected bits. The new field value is taken from wr_data[15:0] for a half write and from wr_data[7:0] for either byte write.
- R7: A byte-size access (code 2'b10 or 2'b11) to indices 4 to 7 is illegal. An illegal read returns zero data and raises that port's illegal flag one cycle later. An illegal write leaves the register unchanged and raises wr_illegal one cycle later.
- R8: When a read and a committed write name the same register in the same cycle, the read returns the value after the merge.
- R9: The two read ports are independent. Each port may address any register at any size in the same cycle.
- R10: When wr_en is low, no register changes and wr_illegal is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 access size |
| rd0_data | output | 32 | Read port 0 result, registered |
| rd0_illegal | output | 1 | Read port 0 illegal-access flag, registered |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 access size |
| rd1_data | output | 32 | Read port 1 result, registered |
| rd1_illegal | output | 1 | Read port 1 illegal-access flag, registered |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data, low-aligned for narrow sizes |
| wr_illegal | output | 1 | Illegal-write flag, registered |

## Verification
A wrong stored value stays hidden until the register is read. Once it is read, it shows on the next cycle as a mismatch in exactly the bit field that was written or wrongly preserved. For that reason the stimulus reads back each register at every size after narrow writes. A bad merge or bad bypass selection shows only in the cycle in which a read and a write collide, so those collisions are created on purpose in addition to arising from random traffic. An error in the legality check shows in the same cycle on two outputs: the illegal flag and the data, which is then nonzero or wrongly zero.

// File: rtl/prf_pkg.sv
package prf_pkg;
  typedef enum logic [1:0] {
    SZ_FULL    = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_BYTE_LO = 2'b10,
    SZ_BYTE_HI = 2'b11
  } prf_size_e;
endpackage

// File: rtl/prf_access_check.sv
module prf_access_check #(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  output logic             legal
);
  // Both byte codes carry bit 1 set; only the lower registers own byte lanes.
  always_comb begin
    legal = 1'b1;
    if (size[1] && (32'(idx) >= BYTE_REGS)) legal = 1'b0;
  end
endmodule

// File: rtl/prf_read_format.sv
module prf_read_format
  import prf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    result = '0;
    unique case (prf_size_e'(size))
      SZ_FULL:    result = value;
      SZ_HALF:    result[15:0] = value[15:0];
      SZ_BYTE_LO: result[7:0] = value[7:0];
      SZ_BYTE_HI: result[7:0] = value[15:8];
      default:    result = '0;
    endcase
  end
endmodule

// File: rtl/prf_write_merge.sv
module prf_write_merge
  import prf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    merged = old_val;
    unique case (prf_size_e'(size))
      SZ_FULL:    merged = new_val;
      SZ_HALF:    merged[15:0] = new_val[15:0];
      SZ_BYTE_LO: merged[7:0] = new_val[7:0];
      SZ_BYTE_HI: merged[15:8] = new_val[7:0];
      default:    merged = old_val;
    endcase
  end
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile #(
  parameter int NUM_REGS  = 8,
  parameter int BYTE_REGS = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int RD_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_illegal,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_illegal,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  // Write path
  logic              wr_legal;
  logic              wr_commit;
  logic [DATA_W-1:0] wr_merged;
  logic              wr_illegal_q;

  prf_access_check #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_wr_chk (
    .idx(wr_idx), .size(wr_size), .legal(wr_legal)
  );

  prf_write_merge #(.DATA_W(DATA_W)) u_merge (
    .old_val(regs[wr_idx]), .new_val(wr_data), .size(wr_size), .merged(wr_merged)
  );

  assign wr_commit = wr_en && wr_legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      wr_illegal_q <= 1'b0;
    end else begin
      if (wr_commit) regs[wr_idx] <= wr_merged;
      wr_illegal_q <= wr_en && !wr_legal;
    end
  end

  assign wr_illegal = wr_illegal_q;

  // Read paths
  logic [IDX_W-1:0]  rd_idx_a  [RD_PORTS];
  logic [1:0]        rd_size_a [RD_PORTS];
  logic [DATA_W-1:0] rd_q      [RD_PORTS];
  logic              rd_ill_q  [RD_PORTS];

  assign rd_idx_a[0]  = rd0_idx;
  assign rd_idx_a[1]  = rd1_idx;
  assign rd_size_a[0] = rd0_size;
  assign rd_size_a[1] = rd1_size;

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    logic              legal;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] shaped;

    prf_access_check #(.NUM_REGS(NUM_REGS), .BYTE_REGS(BYTE_REGS)) u_chk (
      .idx(rd_idx_a[g]), .size(rd_size_a[g]), .legal(legal)
    );

    // Write-first: a colliding committed write is forwarded.
    assign src = (wr_commit && (wr_idx == rd_idx_a[g])) ? wr_merged : regs[rd_idx_a[g]];

    prf_read_format #(.DATA_W(DATA_W)) u_fmt (
      .value(src), .size(rd_size_a[g]), .result(shaped)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q[g]     <= '0;
        rd_ill_q[g] <= 1'b0;
      end else begin
        rd_q[g]     <= legal ? shaped : '0;
        rd_ill_q[g] <= !legal;
      end
    end
  end

  assign rd0_data    = rd_q[0];
  assign rd0_illegal = rd_ill_q[0];
  assign rd1_data    = rd_q[1];
  assign rd1_illegal = rd_ill_q[1];

  // Assertions
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (rd0_data == '0 && rd1_data == '0 && !rd0_illegal && !rd1_illegal && !wr_illegal));

  p_narrow_keeps_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size != 2'b00) |=>
      regs[$past(wr_idx)][DATA_W-1:16] == $past(regs[wr_idx][DATA_W-1:16]));

  p_illegal_write_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_legal) |=> (wr_illegal && regs[$past(wr_idx)] == $past(regs[wr_idx])));

  p_illegal_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rd0_illegal |-> rd0_data == '0);

  p_byte_read_narrow_r4: assert property (@(posedge clk) disable iff (rst)
    rd1_size[1] |=> rd1_data[DATA_W-1:8] == '0);

  p_idle_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_illegal);
endmodule

// File: tb/prf_regfile_test.sv
module prf_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  rd0_idx, rd1_idx, wr_idx;
  logic [1:0]  rd0_size, rd1_size, wr_size;
  logic [31:0] rd0_data, rd1_data, wr_data;
  logic        rd0_illegal, rd1_illegal, wr_en, wr_illegal;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  prf_regfile uut (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal)
  );

  function automatic bit ok_access(logic [2:0] idx, logic [1:0] sz);
    return !(sz[1] && idx >= 3'd4);
  endfunction

  function automatic logic [31:0] view(logic [31:0] v, logic [1:0] sz);
    case (sz)
      2'b00:   return v;
      2'b01:   return {16'h0, v[15:0]};
      2'b10:   return {24'h0, v[7:0]};
      default: return {24'h0, v[15:8]};
    endcase
  endfunction

  function automatic logic [31:0] blend(logic [31:0] o, logic [31:0] n, logic [1:0] sz);
    case (sz)
      2'b00:   return n;
      2'b01:   return {o[31:16], n[15:0]};
      2'b10:   return {o[31:8], n[7:0]};
      default: return {o[31:16], n[7:0], o[7:0]};
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, advance one cycle, check at the next falling edge.
  task automatic cyc(string tag, logic r,
                     logic [2:0] i0, logic [1:0] s0, logic [2:0] i1, logic [1:0] s1,
                     logic we, logic [2:0] wi, logic [1:0] ws, logic [31:0] wd);
    logic [31:0] e0, e1, upd;
    logic ei0, ei1, ewi;
    bit commit;
    rst = r; rd0_idx = i0; rd0_size = s0; rd1_idx = i1; rd1_size = s1;
    wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
    if (r) begin
      e0 = 0; e1 = 0; ei0 = 0; ei1 = 0; ewi = 0;
      for (int k = 0; k < 8; k++) model[k] = 32'h0;
    end else begin
      commit = we && ok_access(wi, ws);
      upd = blend(model[wi], wd, ws);
      ei0 = !ok_access(i0, s0);
      ei1 = !ok_access(i1, s1);
      e0 = ei0 ? 32'h0 : view((commit && wi == i0) ? upd : model[i0], s0);
      e1 = ei1 ? 32'h0 : view((commit && wi == i1) ? upd : model[i1], s1);
      ewi = we && !ok_access(wi, ws);
      if (commit) model[wi] = upd;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rd0_data", rd0_data, e0);
    check(tag, "rd0_illegal", {31'h0, rd0_illegal}, {31'h0, ei0});
    check(tag, "rd1_data", rd1_data, e1);
    check(tag, "rd1_illegal", {31'h0, rd1_illegal}, {31'h0, ei1});
    check(tag, "wr_illegal", {31'h0, wr_illegal}, {31'h0, ewi});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset clears outputs and contents
    cyc("R1", 1, 0, 0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 8; k += 2) cyc("R1", 0, 3'(k), 2'b00, 3'(k + 1), 2'b00, 0, 0, 0, 0);
    // R2: full write and read
    cyc("R2", 0, 0, 0, 0, 0, 1, 0, 2'b00, 32'h1122_3344);
    cyc("R2", 0, 0, 2'b00, 0, 2'b00, 0, 0, 0, 0);
    // R6: narrow merges
    cyc("R6", 0, 1, 0, 1, 0, 1, 0, 2'b01, 32'hAAAA_5555);
    cyc("R6", 0, 0, 2'b00, 0, 2'b01, 1, 0, 2'b10, 32'hFFFF_FF77);
    cyc("R6", 0, 0, 2'b00, 0, 2'b10, 1, 0, 2'b11, 32'hFFFF_FF99);
    cyc("R6", 0, 0, 2'b00, 0, 2'b00, 0, 0, 0, 0);
    // R3 R4 R5: narrow views of 0x11229977
    cyc("R3", 0, 0, 2'b01, 0, 2'b01, 0, 0, 0, 0);
    cyc("R4", 0, 0, 2'b10, 0, 2'b10, 0, 0, 0, 0);
    cyc("R5", 0, 0, 2'b11, 0, 2'b11, 0, 0, 0, 0);
    // R7: byte access to an upper register
    cyc("R7", 0, 0, 0, 0, 0, 1, 5, 2'b00, 32'hDEAD_BEEF);
    cyc("R7", 0, 5, 2'b10, 5, 2'b11, 1, 5, 2'b10, 32'h0000_0012);
    cyc("R7", 0, 5, 2'b00, 5, 2'b01, 1, 5, 2'b11, 32'h0000_0034);
    cyc("R7", 0, 5, 2'b00, 4, 2'b10, 0, 0, 0, 0);
    // R8: same-cycle bypass, full and narrow
    cyc("R8", 0, 2, 2'b00, 2, 2'b01, 1, 2, 2'b00, 32'hCAFE_F00D);
    cyc("R8", 0, 2, 2'b00, 2, 2'b11, 1, 2, 2'b11, 32'h0000_00AB);
    // R10: disabled write leaves state alone
    cyc("R10", 0, 0, 0, 0, 0, 0, 2, 2'b00, 32'h0BAD_0BAD);
    cyc("R10", 0, 2, 2'b00, 2, 2'b00, 0, 5, 2'b10, 32'h0);
    // R9: independent ports under random traffic
    for (int n = 0; n < 400; n++)
      cyc("R9", 0, 3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom),
          1'($urandom), 3'($urandom), 2'($urandom), $urandom);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule